// File: doc/BRIEF.md
# Alternating Interval Pulse Timer

The block produces a continuous rectangular wave whose high time and low time are programmed independently. A single reloadable down counter times both phases: when it runs out, the output level flips and the counter is reloaded in that same cycle with the length of the phase just starting. Each count is one system clock, so at 25 MHz a phase length is set in 40 ns steps. The high length and the low length add up to the repetition period, so width and rate come from one timing chain instead of two separate timers.

The two lengths are either taken from input ports or fixed at compile time through parameters, chosen by the `USE_PORTS` parameter. A length is read only at the reload that starts its phase, so a running phase is never cut short or stretched by a new setting. A length of zero is treated as one clock, so the output can never stop toggling.

Top module: `alt_interval_pulse`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pulse_o` is 0 after that edge. The first low phase after reset lasts max(`off_len`,1) clocks, using the value of `off_len` at the last reset edge.
- R2: Each high phase of `pulse_o` lasts exactly max(H,1) clocks, where H is the high length in effect at the edge where `pulse_o` rose.
- R3: Each low phase of `pulse_o` lasts exactly max(L,1) clocks, where L is the low length in effect at the edge where `pulse_o` fell.
- R4: A high phase followed by a low phase spans exactly the sum of their two lengths; the output changes level only at the edge where the counter expires.
- R5: A change of `on_len` or `off_len` during a phase has no effect on the phase in progress; the new value takes effect at the next phase of its own kind.
- R6: A length of zero gives a phase of one clock; with both lengths zero, `pulse_o` toggles on every clock.
- R7: With `USE_PORTS` = 0, the lengths come from the parameters `FIX_ON` and `FIX_OFF`, and the `on_len` and `off_len` ports have no effect on `pulse_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one count per cycle |
| rst | input | 1 | Synchronous active-high reset |
| on_len | input | CNT_W | High phase length in clocks (zero means one) |
| off_len | input | CNT_W | Low phase length in clocks (zero means one) |
| pulse_o | output | 1 | Registered pulse output |

## Verification
Two events can occur in the same cycle: the counter expiring (which flips the level and reloads) and a new value arriving on a length port. The bench changes `on_len` and `off_len` at random moments, so some changes land on the very edge of a reload, and it also holds lengths at zero to force a reload on every cycle. Each completed phase is measured at the output and compared with the length present at the edge that started it. A phase changed in flight must still have its starting length.

// File: rtl/alt_interval_pkg.sv
package alt_interval_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/setpoint_src.sv
module setpoint_src #(
  parameter int CNT_W     = 16,
  parameter bit USE_PORTS = 1'b1,
  parameter int FIX_ON    = 10,
  parameter int FIX_OFF   = 20
) (
  input  logic [CNT_W-1:0] on_in,
  input  logic [CNT_W-1:0] off_in,
  output logic [CNT_W-1:0] on_ld,
  output logic [CNT_W-1:0] off_ld
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // A length L is loaded as L-1; zero is clamped to a one-clock phase.
  function automatic logic [CNT_W-1:0] to_load(input logic [CNT_W-1:0] len);
    return (len == '0) ? '0 : len - ONE;
  endfunction

  generate
    if (USE_PORTS) begin : g_ports
      assign on_ld  = to_load(on_in);
      assign off_ld = to_load(off_in);
    end else begin : g_fixed
      localparam logic [CNT_W-1:0] FON  = CNT_W'(FIX_ON);
      localparam logic [CNT_W-1:0] FOFF = CNT_W'(FIX_OFF);
      logic unused_ports;
      assign unused_ports = ^{on_in, off_in};
      assign on_ld  = to_load(FON);
      assign off_ld = to_load(FOFF);
    end
  endgenerate
endmodule

// File: rtl/interval_counter.sv
module interval_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rst_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  assign expire = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= rst_val;
    end else if (expire) begin
      cnt_q <= reload_val;
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/phase_reg.sv
module phase_reg
  import alt_interval_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   expire,
  output phase_e phase_q,
  output logic   pulse_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_LOW;
      pulse_o <= 1'b0;
    end else if (expire) begin
      phase_q <= (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
      pulse_o <= (phase_q == PH_LOW);
    end
  end
endmodule

// File: rtl/alt_interval_pulse.sv
module alt_interval_pulse
  import alt_interval_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter bit USE_PORTS = 1'b1,
  parameter int FIX_ON    = 10,
  parameter int FIX_OFF   = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] on_len,
  input  logic [CNT_W-1:0] off_len,
  output logic             pulse_o
);
  logic [CNT_W-1:0] on_ld;
  logic [CNT_W-1:0] off_ld;
  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] cnt_q;
  logic             expire;
  phase_e           phase_q;

  setpoint_src #(
    .CNT_W(CNT_W), .USE_PORTS(USE_PORTS), .FIX_ON(FIX_ON), .FIX_OFF(FIX_OFF)
  ) u_src (
    .on_in(on_len), .off_in(off_len), .on_ld(on_ld), .off_ld(off_ld)
  );

  // The phase about to start after an expiry is the opposite of the current one.
  assign reload_val = (phase_q == PH_LOW) ? on_ld : off_ld;

  interval_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .rst_val(off_ld), .reload_val(reload_val),
    .cnt_q(cnt_q), .expire(expire)
  );

  phase_reg u_phase (
    .clk(clk), .rst(rst), .expire(expire), .phase_q(phase_q), .pulse_o(pulse_o)
  );
endmodule

// File: rtl/alt_interval_pulse_chk.sv
module alt_interval_pulse_chk #(
  parameter int CNT_W     = 16,
  parameter bit USE_PORTS = 1'b1,
  parameter int FIX_ON    = 10,
  parameter int FIX_OFF   = 20
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] on_len,
  input logic [CNT_W-1:0] off_len,
  input logic             pulse_o,
  input logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] raw_on, raw_off, want_on, want_off;

  always_comb begin
    raw_on   = USE_PORTS ? on_len  : CNT_W'(FIX_ON);
    raw_off  = USE_PORTS ? off_len : CNT_W'(FIX_OFF);
    want_on  = (raw_on  == '0) ? '0 : raw_on  - CNT_W'(1);
    want_off = (raw_off == '0) ? '0 : raw_off - CNT_W'(1);
  end

  p_low_in_reset_r1: assert property (@(posedge clk)
    rst |=> (!pulse_o && cnt_q == $past(want_off)));

  p_hold_level_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |=> $stable(pulse_o));

  p_count_down_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  p_flip_on_expiry_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0) |=> (pulse_o != $past(pulse_o)));

  p_load_high_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !pulse_o) |=> (cnt_q == $past(want_on)));

  p_load_low_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && pulse_o) |=> (cnt_q == $past(want_off)));
endmodule

bind alt_interval_pulse alt_interval_pulse_chk #(
  .CNT_W(CNT_W), .USE_PORTS(USE_PORTS), .FIX_ON(FIX_ON), .FIX_OFF(FIX_OFF)
) u_chk (
  .clk(clk), .rst(rst), .on_len(on_len), .off_len(off_len),
  .pulse_o(pulse_o), .cnt_q(cnt_q)
);

// File: tb/sim_alt_interval_pulse.sv
module sim_alt_interval_pulse;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int F_ON = 3;
  localparam int F_OFF = 0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] on_len = 16'd4;
  logic [W-1:0] off_len = 16'd6;
  logic pulse0, pulse1;
  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alt_interval_pulse #(.CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .on_len(on_len), .off_len(off_len), .pulse_o(pulse0));

  alt_interval_pulse #(.CNT_W(W), .USE_PORTS(1'b0), .FIX_ON(F_ON), .FIX_OFF(F_OFF)) u1 (
    .clk(clk), .rst(rst), .on_len(on_len), .off_len(off_len), .pulse_o(pulse1));

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor for u0: lengths seen at the previous negedge were present at the edge just passed.
  int sv_on, sv_off, lvl, run, exp_len, raw_len, hi_run, hi_exp;
  bit started = 0, first = 0, changed = 0, have_hi = 0;
  // Monitor for u1 (fixed lengths).
  int lvl1, run1;
  bit started1 = 0;

  always @(negedge clk) begin
    if (!done) begin
      if (rst) begin
        started = 0; started1 = 0;
      end else if (!started) begin
        started = 1; first = 1; changed = 0; have_hi = 0;
        chk("R1 level after reset", pulse0, 0);
        lvl = 0; run = 1; raw_len = sv_off; exp_len = eff(sv_off);
      end else if (pulse0 == lvl) begin
        run++;
        if ((lvl ? sv_on : sv_off) != raw_len) changed = 1;
      end else begin
        if (first)            chk("R1 first low phase", run, exp_len);
        else if (changed)     chk("R5 phase with mid-phase change", run, exp_len);
        else if (raw_len == 0) chk("R6 zero length phase", run, exp_len);
        else if (lvl == 1)    chk("R2 high phase length", run, exp_len);
        else                  chk("R3 low phase length", run, exp_len);
        if (lvl == 1) begin
          hi_run = run; hi_exp = exp_len; have_hi = 1;
        end else if (have_hi) begin
          chk("R4 period", hi_run + run, hi_exp + exp_len);
        end
        first = 0; changed = 0;
        lvl = pulse0; run = 1;
        raw_len = pulse0 ? sv_on : sv_off;
        exp_len = eff(raw_len);
      end

      if (!rst) begin
        if (!started1) begin
          started1 = 1; lvl1 = pulse1; run1 = 1;
          chk("R7 fixed mode level after reset", pulse1, 0);
        end else if (pulse1 == lvl1) begin
          run1++;
        end else begin
          chk("R7 fixed mode phase length", run1, lvl1 ? eff(F_ON) : eff(F_OFF));
          lvl1 = pulse1; run1 = 1;
        end
      end
      sv_on = on_len; sv_off = off_len;
    end
  end

  task automatic set_len(input int a, input int b);
    @(posedge clk); #1;
    on_len = W'(a); off_len = W'(b);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    idle(120);                 // R2/R3 on=4 off=6
    set_len(0, 0); idle(40);   // R6 toggle every clock
    set_len(0, 3); idle(40);
    set_len(5, 0); idle(40);
    set_len(200, 1); idle(450);
    set_len(2, 7); idle(20);
    // reset in the middle of a phase, with a new low length
    @(posedge clk); #1 rst = 1'b1; off_len = 16'd9;
    idle(3); #1 rst = 1'b0;
    idle(60);
    // random lengths changed at random moments, some landing on reload edges
    for (int i = 0; i < 12000; i++) begin
      @(posedge clk); #1;
      if ($urandom_range(0, 5) == 0) on_len  = W'($urandom_range(0, 24));
      if ($urandom_range(0, 5) == 0) off_len = W'($urandom_range(0, 24));
    end
    idle(60);
    @(negedge clk);
    done = 1'b1;
    if (nchk < 50) chk("R2 enough completed phases", nchk, 50);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule